// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block is a byte-wide, two-way mailbox between an external host bus and the processor of a local controller. Each side sees the same pair of registers: a data port at 80H and a status port at 81H. A byte written on one side lands in that direction's holding register and raises a "full" flag. The other side sees the flag in its status port. Reading the byte on the receiving side clears the flag, so software never writes the status port.

The host side qualifies its I/O cycles with separate status lines and strobes. A write needs the output-status line together with the write strobe. A read needs the input-status line together with the data-bus-in strobe. The 16-bit port address must have a zero upper byte. Both strobes are asynchronous to the block clock and pass through a synchroniser. A data-port access takes effect when the synchronised strobe falls.

Each direction behaves as a one-deep stream. A holding register is valid while its full flag is set and is ready again once the receiver reads it. Back-pressure is advisory: the sender is expected to poll its status port before writing. A write into a full register still replaces the byte, and it records a sticky overrun that only the local side can see.

The block is used for a short link-up exchange (the host writes 21H and reads 21H back), single-byte commands, 512-byte sector streams, and F0H completion bytes.

Top module: `mbx_bridge`

## Requirements
- R1: After reset both full flags and the overrun bit are clear. Both status ports read 00H.
- R2: The host side ignores an access whose port address has a non-zero upper byte or a low byte other than 80H/81H. Such a read returns 00H. Host writes to the status port (81H) change nothing.
- R3: A host write to 80H (output-status high with write strobe) stores the byte and sets status bit 0 once the strobe has ended. This takes at most three clocks after the strobe falls.
- R4: A local read of 80H returns the host's byte and clears status bit 0 on the next clock.
- R5: A local write to 80H stores the byte and sets status bit 7. A host read of 80H (input-status high with data-in strobe) returns that byte and clears bit 7 after the strobe ends.
- R6: The host status port shows bit 0 as host-to-local full and bit 7 as local-to-host full, with all other bits zero. The local status port adds bit 1 as overrun. Reading a status port clears no full flag.
- R7: A write into a full holding register replaces its byte and sets overrun (local status bit 1). The bit stays set until the local side reads its status port; that read reports it and clears it.
- R8: A host write strobe without output-status, or a data-in strobe without input-status, has no effect.
- R9: If a write and the clearing read of the same register land on the same clock, the new byte is kept, the flag stays set, and no overrun is raised.
- R10: A sequence of bytes passed one at a time in either direction arrives complete and in order with no overrun. This covers the 21H link-up echo and a closing F0H completion byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_addr | input | 16 | Host I/O port address |
| h_sinp | input | 1 | Host input-cycle status line |
| h_sout | input | 1 | Host output-cycle status line |
| h_wr_stb | input | 1 | Host write strobe (asynchronous) |
| h_din_stb | input | 1 | Host data-bus-in strobe (asynchronous) |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, 00H when not selected |
| l_addr | input | 8 | Local port address |
| l_wr | input | 1 | Local write, one clock per access |
| l_rd | input | 1 | Local read, one clock per access |
| l_wdata | input | 8 | Local write data |
| l_rdata | output | 8 | Local read data |

## Verification
The assertions watch the flag protocol on every cycle:
- each completed write sets its flag on the next clock;
- a clearing read with no competing write drops the flag;
- a flag holds when no event touches it;
- overrun stays set until a local status read;
- a host address with a non-zero upper byte never drives read data.

Some behaviours show only through the bench scenarios:
- byte values and ordering across a stream;
- the delay from strobe release through the synchroniser;
- the exact same-clock collision of a host read with a local write;
- rejection of strobes that lack their status qualifier.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // status bit positions; the host-side software decodes these
  localparam int STAT_H2L_BIT = 0;
  localparam int STAT_OVR_BIT = 1;
  localparam int STAT_L2H_BIT = 7;
  localparam int BYTE_W       = 8;
endpackage

// File: rtl/mbx_strobe_sync.sv
module mbx_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_raw,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= strobe_raw;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          clr,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          ovr_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      if (wr) data <= wdata;
      if (wr)       full <= 1'b1;
      else if (clr) full <= 1'b0;
    end
  end

  // overwrite of an unread byte, unless the reader takes it this same clock
  assign ovr_evt = wr & full & ~clr;
endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port #(
  parameter int          DW        = 8,
  parameter int          AW        = 16,
  parameter int          PW        = 8,
  parameter logic [7:0]  DATA_PORT = 8'h80,
  parameter logic [7:0]  STAT_PORT = 8'h81,
  parameter int          STAGES    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] h_addr,
  input  logic          h_sinp,
  input  logic          h_sout,
  input  logic          h_wr_stb,
  input  logic          h_din_stb,
  input  logic [DW-1:0] h_wdata,
  input  logic [DW-1:0] l2h_data,
  input  logic [DW-1:0] stat,
  output logic [DW-1:0] h_rdata,
  output logic          wr_evt,
  output logic          rd_evt,
  output logic [DW-1:0] wdata
);
  logic          hi_zero, sel_data, sel_stat;
  logic          wr_raw, rd_raw;
  logic          wr_rise, wr_fall, rd_rise, rd_fall;
  logic          cap_wr_sel, cap_rd_sel;
  logic [DW-1:0] cap_wdata;

  assign hi_zero  = (h_addr[AW-1:PW] == '0);
  assign sel_data = hi_zero && (h_addr[PW-1:0] == PW'(DATA_PORT));
  assign sel_stat = hi_zero && (h_addr[PW-1:0] == PW'(STAT_PORT));
  assign wr_raw   = h_sout & h_wr_stb;
  assign rd_raw   = h_sinp & h_din_stb;

  mbx_strobe_sync #(.STAGES(STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_raw(wr_raw), .rise(wr_rise), .fall(wr_fall)
  );
  mbx_strobe_sync #(.STAGES(STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_raw(rd_raw), .rise(rd_rise), .fall(rd_fall)
  );

  // decode and data are captured while the strobe is still high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_wr_sel <= 1'b0;
      cap_rd_sel <= 1'b0;
      cap_wdata  <= '0;
    end else begin
      if (wr_rise) begin
        cap_wr_sel <= sel_data;
        cap_wdata  <= h_wdata;
      end
      if (rd_rise) cap_rd_sel <= sel_data;
    end
  end

  assign wr_evt = wr_fall & cap_wr_sel;
  assign rd_evt = rd_fall & cap_rd_sel;
  assign wdata  = cap_wdata;

  always_comb begin
    h_rdata = '0;
    if (rd_raw && sel_data)      h_rdata = l2h_data;
    else if (rd_raw && sel_stat) h_rdata = stat;
  end
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge #(
  parameter int         DW          = 8,
  parameter int         AW          = 16,
  parameter int         PW          = 8,
  parameter logic [7:0] DATA_PORT   = 8'h80,
  parameter logic [7:0] STAT_PORT   = 8'h81,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] h_addr,
  input  logic          h_sinp,
  input  logic          h_sout,
  input  logic          h_wr_stb,
  input  logic          h_din_stb,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic [PW-1:0] l_addr,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata
);
  import mbx_pkg::*;

  logic          host_wr_evt, host_rd_evt;
  logic [DW-1:0] host_wdata;
  logic [DW-1:0] h2l_data, l2h_data;
  logic          h2l_full, l2h_full, h2l_ovr, l2h_ovr, ovr_q;
  logic          loc_sel_data, loc_sel_stat;
  logic          loc_wr_data, loc_rd_data, loc_rd_stat;
  logic [DW-1:0] host_stat, loc_stat;

  assign loc_sel_data = (l_addr == PW'(DATA_PORT));
  assign loc_sel_stat = (l_addr == PW'(STAT_PORT));
  assign loc_wr_data  = l_wr & loc_sel_data;
  assign loc_rd_data  = l_rd & loc_sel_data;
  assign loc_rd_stat  = l_rd & loc_sel_stat;

  mbx_host_port #(
    .DW(DW), .AW(AW), .PW(PW), .DATA_PORT(DATA_PORT),
    .STAT_PORT(STAT_PORT), .STAGES(SYNC_STAGES)
  ) u_host (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_sinp(h_sinp), .h_sout(h_sout),
    .h_wr_stb(h_wr_stb), .h_din_stb(h_din_stb), .h_wdata(h_wdata),
    .l2h_data(l2h_data), .stat(host_stat), .h_rdata(h_rdata),
    .wr_evt(host_wr_evt), .rd_evt(host_rd_evt), .wdata(host_wdata)
  );

  // host -> local holding register
  mbx_slot #(.DW(DW)) u_h2l (
    .clk(clk), .rst_n(rst_n), .wr(host_wr_evt), .wdata(host_wdata),
    .clr(loc_rd_data), .data(h2l_data), .full(h2l_full), .ovr_evt(h2l_ovr)
  );

  // local -> host holding register
  mbx_slot #(.DW(DW)) u_l2h (
    .clk(clk), .rst_n(rst_n), .wr(loc_wr_data), .wdata(l_wdata),
    .clr(host_rd_evt), .data(l2h_data), .full(l2h_full), .ovr_evt(l2h_ovr)
  );

  // sticky overrun, cleared by a local status read; a new event wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= (ovr_q & ~loc_rd_stat) | h2l_ovr | l2h_ovr;
  end

  always_comb begin
    host_stat               = '0;
    host_stat[STAT_H2L_BIT] = h2l_full;
    host_stat[STAT_L2H_BIT] = l2h_full;
    loc_stat                = host_stat;
    loc_stat[STAT_OVR_BIT]  = ovr_q;
  end

  always_comb begin
    l_rdata = '0;
    if (loc_sel_data)      l_rdata = h2l_data;
    else if (loc_sel_stat) l_rdata = loc_stat;
  end
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int AW = 16,
  parameter int PW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr_evt,
  input logic          host_rd_evt,
  input logic          loc_wr_data,
  input logic          loc_rd_data,
  input logic          loc_rd_stat,
  input logic          h2l_full,
  input logic          l2h_full,
  input logic          ovr_q,
  input logic [AW-1:0] h_addr,
  input logic [DW-1:0] h_rdata
);
  AST_H2L_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_evt |=> h2l_full);  // R3
  AST_H2L_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    loc_rd_data && !host_wr_evt |=> !h2l_full);  // R4
  AST_L2H_SET: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr_data |=> l2h_full);  // R5
  AST_L2H_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_evt && !loc_wr_data |=> !l2h_full);  // R5
  AST_H2L_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr_evt && !loc_rd_data |=> $stable(h2l_full));  // R2
  AST_L2H_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_wr_data && !host_rd_evt |=> $stable(l2h_full));  // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !loc_rd_stat |=> ovr_q);  // R7
  AST_OVR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr_data && l2h_full && !host_rd_evt |=> ovr_q);  // R7
  AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr_data && host_rd_evt && !ovr_q && !host_wr_evt |=> l2h_full && !ovr_q);  // R9
  AST_FAR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (h_addr[AW-1:PW] != '0) |-> (h_rdata == '0));  // R2
endmodule

bind mbx_bridge mbx_bridge_chk #(.AW(AW), .PW(PW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr_evt(host_wr_evt), .host_rd_evt(host_rd_evt),
  .loc_wr_data(loc_wr_data), .loc_rd_data(loc_rd_data), .loc_rd_stat(loc_rd_stat),
  .h2l_full(h2l_full), .l2h_full(l2h_full), .ovr_q(ovr_q),
  .h_addr(h_addr), .h_rdata(h_rdata)
);

// File: tb/sim_mbx_bridge.sv
module sim_mbx_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] h_addr = '0;
  logic        h_sinp = 1'b0, h_sout = 1'b0, h_wr_stb = 1'b0, h_din_stb = 1'b0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic [7:0]  l_addr = '0;
  logic        l_wr = 1'b0, l_rd = 1'b0;
  logic [7:0]  l_wdata = '0;
  logic [7:0]  l_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] h2l_q[$];  // scoreboard: bytes expected at local side
  logic [7:0] l2h_q[$];  // scoreboard: bytes expected at host side

  always #10 clk = ~clk;  // 50 MHz

  mbx_bridge u0 (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_sinp(h_sinp), .h_sout(h_sout),
    .h_wr_stb(h_wr_stb), .h_din_stb(h_din_stb), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .l_addr(l_addr), .l_wr(l_wr), .l_rd(l_rd), .l_wdata(l_wdata), .l_rdata(l_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [15:0] a, input logic [7:0] d, input bit qual);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_sout = qual; h_wr_stb = 1'b1;
    repeat (4) @(negedge clk);
    h_wr_stb = 1'b0;
    repeat (5) @(negedge clk);
    h_sout = 1'b0;
  endtask

  task automatic host_read(input logic [15:0] a, input bit qual, output logic [7:0] d);
    @(negedge clk);
    h_addr = a; h_sinp = qual; h_din_stb = 1'b1;
    repeat (3) @(negedge clk);
    #1 d = h_rdata;
    @(negedge clk);
    h_din_stb = 1'b0;
    repeat (5) @(negedge clk);
    h_sinp = 1'b0;
  endtask

  task automatic loc_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    l_addr = a; l_rd = 1'b1;
    #1 d = l_rdata;
    @(negedge clk);
    l_rd = 1'b0;
  endtask

  task automatic loc_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    l_addr = a; l_wdata = d; l_wr = 1'b1;
    @(negedge clk);
    l_wr = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic host_send(input logic [7:0] d);
    h2l_q.push_back(d);
    host_write(16'h0080, d, 1'b1);
  endtask

  task automatic loc_send(input logic [7:0] d);
    l2h_q.push_back(d);
    loc_write(8'h80, d);
  endtask

  // monitor side of the scoreboard
  task automatic loc_recv(input string req);
    logic [7:0] got, exp;
    loc_read(8'h80, got);
    exp = (h2l_q.size() > 0) ? h2l_q.pop_front() : 8'hxx;
    check(req, got, exp);
  endtask

  task automatic host_recv(input string req);
    logic [7:0] got, exp;
    host_read(16'h0080, 1'b1, got);
    exp = (l2h_q.size() > 0) ? l2h_q.pop_front() : 8'hxx;
    check(req, got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    host_read(16'h0081, 1'b1, d); check("R1 host status", d, 8'h00);
    loc_read(8'h81, d);           check("R1 local status", d, 8'h00);

    // R3/R4/R6/R10 link-up echo
    host_send(8'h21);
    loc_read(8'h81, d);           check("R3 bit0 set", d, 8'h01);
    host_read(16'h0081, 1'b1, d); check("R6 host status bit0", d, 8'h01);
    loc_recv("R10 link byte");
    loc_read(8'h81, d);           check("R4 bit0 cleared", d, 8'h00);
    loc_send(8'h21);
    host_read(16'h0081, 1'b1, d); check("R6 host status bit7", d, 8'h80);
    host_read(16'h0081, 1'b1, d); check("R6 status read keeps flag", d, 8'h80);
    host_recv("R5 echo byte");
    host_read(16'h0081, 1'b1, d); check("R5 bit7 cleared", d, 8'h00);

    // R2 address decode
    host_write(16'h0180, 8'h55, 1'b1);
    host_write(16'h0082, 8'h56, 1'b1);
    host_write(16'h0081, 8'hFF, 1'b1);
    loc_read(8'h81, d);           check("R2 foreign writes ignored", d, 8'h00);
    loc_write(8'h80, 8'h3C);
    host_read(16'h0180, 1'b1, d); check("R2 far read data", d, 8'h00);
    loc_read(8'h81, d);           check("R2 far read no clear", d, 8'h80);

    // R8 unqualified strobes
    host_read(16'h0080, 1'b0, d); check("R8 unqualified read data", d, 8'h00);
    loc_read(8'h81, d);           check("R8 unqualified read no clear", d, 8'h80);
    host_write(16'h0080, 8'h77, 1'b0);
    loc_read(8'h81, d);           check("R8 unqualified write ignored", d, 8'h80);
    host_read(16'h0080, 1'b1, d); check("R8 byte intact", d, 8'h3C);

    // R7 host-side overrun
    host_write(16'h0080, 8'h11, 1'b1);
    host_write(16'h0080, 8'h22, 1'b1);
    loc_read(8'h81, d);           check("R7 overrun reported", d, 8'h03);
    loc_read(8'h80, d);           check("R7 newest byte kept", d, 8'h22);
    loc_read(8'h81, d);           check("R7 overrun cleared", d, 8'h00);
    // R7 local-side overrun, hidden from host
    loc_write(8'h80, 8'h33);
    loc_write(8'h80, 8'h44);
    host_read(16'h0081, 1'b1, d); check("R7 host sees no overrun", d, 8'h80);
    host_read(16'h0080, 1'b1, d); check("R7 local newest byte", d, 8'h44);
    loc_read(8'h81, d);           check("R7 local overrun", d, 8'h02);
    loc_read(8'h81, d);           check("R7 overrun sticky clear", d, 8'h00);

    // R9 host read completion collides with a local write
    loc_write(8'h80, 8'hA5);
    @(negedge clk);
    h_addr = 16'h0080; h_sinp = 1'b1; h_din_stb = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R9 old byte read", h_rdata, 8'hA5);
    @(negedge clk);
    h_din_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    l_addr = 8'h80; l_wdata = 8'h5A; l_wr = 1'b1;
    @(negedge clk);
    l_wr = 1'b0;
    repeat (4) @(negedge clk);
    h_sinp = 1'b0;
    loc_read(8'h81, d);           check("R9 flag kept no overrun", d, 8'h80);
    host_read(16'h0080, 1'b1, d); check("R9 new byte kept", d, 8'h5A);

    // R10 streams both ways, ending with completion byte
    for (int i = 0; i < 32; i++) begin
      host_send(8'(i * 7 + 3));
      loc_recv("R10 host to local stream");
    end
    for (int i = 0; i < 32; i++) begin
      loc_send(8'(8'hC0 ^ i));
      host_recv("R10 local to host stream");
    end
    loc_send(8'hF0);
    host_recv("R10 completion byte");
    loc_read(8'h81, d);           check("R10 no overrun after stream", d, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule